// File: doc/BRIEF.md
# Wakeup Pin Monitor

This always-on block watches a group of external wakeup pins while the main processor is powered down. Each input passes through a two-flop synchronizer. A per-pin trigger rule then turns it into an event: rising edge, falling edge, either edge, or an active-high or active-low level. Events on enabled pins are caught in sticky status bits. When an enabled pin has a status bit set, the block raises a registered wake request.

Software programs the block over a simple 32-bit register bus. Reads are combinational on the presented byte address, and a write takes effect at the clock edge where the write strobe is high. The register space holds two free-use timer words followed by five banks of per-pin bits. Before power-down, software clears the status words by writing zeros and then pulses the doorbell input. The block marks itself asleep until a wake request is raised.

Top module: `wake_monitor`

## Requirements
- R1: After reset every timer word and every bank word reads zero, and `wake_req` and `asleep` are 0.
- R2: Word index i = byte address / 4. Indices 0 and 1 are 32-bit read/write timer words. With S = ceil(PINS/32), bank b (0 enable, 1 falling, 2 rising, 3 polarity, 4 status) word w sits at index b*S + w + 2. Pin p uses bit p mod 32 of word p/32. The enable, falling, rising and polarity words read back what was written.
- R3: An address at or above index 5*S + 2, or with either of its two low bits set, reads zero and ignores writes. Bank bits for pin numbers at or above PINS read zero.
- R4: With its rising bit set, an enabled pin that goes from 0 to 1 sets its status bit. If the pin changes before clock edge k, the status bit reads 1 after edge k+2.
- R5: With its falling bit set, an enabled pin going from 1 to 0 sets its status bit. A falling-only pin ignores rising edges. With both edge bits set, either edge sets the status bit.
- R6: With both edge bits clear, an enabled pin is level sensitive. Its status bit is set while the synchronized pin equals its polarity bit (1 means active high, 0 means active low).
- R7: Events on a pin whose enable bit is 0 do not set its status bit.
- R8: Status bits are sticky. Writing 0 to a status bit clears it, and writing 1 has no effect. A detected event in the same cycle as the clear keeps the bit set.
- R9: `wake_req` goes high one cycle after a pin has both its status and enable bits set, and it is low otherwise. Clearing the enable bit drops `wake_req` but keeps the status bit.
- R10: A `doorbell` pulse sets `asleep` at the next edge while `wake_req` is low. `asleep` clears at the edge after `wake_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pins_i | input | PINS | Asynchronous wakeup pin inputs |
| doorbell | input | 1 | Sleep-entry notification pulse |
| wake_req | output | 1 | Registered wake request |
| asleep | output | 1 | Set by doorbell, cleared by wake |

## Verification
Wrong trigger configuration or a broken synchronizer shows up as a status bit that is missing or set when it should not be. A status read three cycles after the pin change exposes it, and `wake_req` follows one cycle later. Broken sticky logic shows up as a status bit that clears under a still-active level or that drops with no write. A fault in address decoding appears on the next read as data in the wrong word or bank, or as nonzero data from unmapped space. A wrong enable gate shows as `wake_req` going high for a disabled pin, or as `wake_req` staying high after software disables the pin.

// File: rtl/wkm_pkg.sv
`timescale 1ns/1ps
package wkm_pkg;
    localparam int WORD_W      = 32;
    localparam int NUM_BANKS   = 5;
    localparam int TIMER_WORDS = 2;

    // bank order is decoded by software, so it is fixed
    typedef enum logic [2:0] {
        BANK_ENABLE = 3'd0,
        BANK_FALL   = 3'd1,
        BANK_RISE   = 3'd2,
        BANK_POL    = 3'd3,
        BANK_STATUS = 3'd4
    } bank_e;

    typedef struct packed {
        logic enable;
        logic rise;
        logic fall;
        logic pol;
    } pin_cfg_t;

    typedef struct packed {
        logic       timer_hit;
        logic       timer_idx;
        logic       bank_hit;
        bank_e      bank;
        logic [7:0] word;
    } reg_sel_t;

    function automatic int stride_of(int pins);
        return (pins + WORD_W - 1) / WORD_W;
    endfunction

    function automatic reg_sel_t decode_addr(int word_idx, int stride);
        reg_sel_t sel;
        int rel;
        int b;
        sel = '0;
        if (word_idx < TIMER_WORDS) begin
            sel.timer_hit = 1'b1;
            sel.timer_idx = word_idx[0];
        end else begin
            rel = word_idx - TIMER_WORDS;
            b   = rel / stride;
            if (b < NUM_BANKS) begin
                sel.bank_hit = 1'b1;
                sel.bank     = bank_e'(b[2:0]);
                sel.word     = 8'(rel % stride);
            end
        end
        return sel;
    endfunction
endpackage

// File: rtl/wkm_sync.sv
`timescale 1ns/1ps
module wkm_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            prev_o <= '0;
        end else begin
            chain[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            prev_o <= chain[STAGES-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/wkm_detect.sv
`timescale 1ns/1ps
module wkm_detect
    import wkm_pkg::*;
#(
    parameter int PINS = 40
) (
    input  logic     [PINS-1:0] cur_i,
    input  logic     [PINS-1:0] prev_i,
    input  pin_cfg_t [PINS-1:0] cfg_i,
    output logic     [PINS-1:0] evt_o
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic up_hit, down_hit, level_hit;
        assign up_hit    = cfg_i[p].rise &  cur_i[p] & ~prev_i[p];
        assign down_hit  = cfg_i[p].fall & ~cur_i[p] &  prev_i[p];
        assign level_hit = ~cfg_i[p].rise & ~cfg_i[p].fall & (cur_i[p] == cfg_i[p].pol);
        assign evt_o[p]  = cfg_i[p].enable & (up_hit | down_hit | level_hit);
    end
endmodule

// File: rtl/wkm_regs.sv
`timescale 1ns/1ps
module wkm_regs
    import wkm_pkg::*;
#(
    parameter int PINS   = 40,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [PINS-1:0]     evt_i,
    output pin_cfg_t [PINS-1:0] cfg_o,
    output logic [PINS-1:0]     en_o,
    output logic [PINS-1:0]     status_o,
    output logic                stat_wr_o
);
    localparam int STRIDE = stride_of(PINS);
    localparam int SPAN   = STRIDE * WORD_W;

    reg_sel_t sel;
    logic     aligned;
    logic [TIMER_WORDS-1:0][WORD_W-1:0] timer_q;
    logic [PINS-1:0] en_q, rise_q, fall_q, pol_q, stat_q;
    logic [SPAN-1:0] mask_pad, val_pad, rd_pad;
    logic [PINS-1:0] wmask, wval;
    logic wr_any, wr_en, wr_rise, wr_fall, wr_pol, wr_stat;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign sel     = decode_addr(int'(bus_addr[ADDR_W-1:2]), STRIDE);
    assign wr_any  = bus_wr & aligned & sel.bank_hit;
    assign wr_en   = wr_any & (sel.bank == BANK_ENABLE);
    assign wr_fall = wr_any & (sel.bank == BANK_FALL);
    assign wr_rise = wr_any & (sel.bank == BANK_RISE);
    assign wr_pol  = wr_any & (sel.bank == BANK_POL);
    assign wr_stat = wr_any & (sel.bank == BANK_STATUS);

    always_comb begin
        mask_pad = '0;
        val_pad  = '0;
        mask_pad[int'(sel.word)*WORD_W +: WORD_W] = '1;
        val_pad[int'(sel.word)*WORD_W +: WORD_W]  = bus_wdata;
    end
    assign wmask = mask_pad[PINS-1:0];
    assign wval  = val_pad[PINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            en_q    <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            pol_q   <= '0;
            stat_q  <= '0;
        end else begin
            if (bus_wr && aligned && sel.timer_hit) begin
                timer_q[sel.timer_idx] <= bus_wdata;
            end
            if (wr_en)   en_q   <= (en_q   & ~wmask) | (wval & wmask);
            if (wr_rise) rise_q <= (rise_q & ~wmask) | (wval & wmask);
            if (wr_fall) fall_q <= (fall_q & ~wmask) | (wval & wmask);
            if (wr_pol)  pol_q  <= (pol_q  & ~wmask) | (wval & wmask);
            // zeros clear, ones keep; a fresh event always wins
            stat_q <= (stat_q & ~(wr_stat ? (wmask & ~wval) : '0)) | evt_i;
        end
    end

    always_comb begin
        rd_pad = '0;
        unique case (sel.bank)
            BANK_ENABLE: rd_pad[PINS-1:0] = en_q;
            BANK_FALL:   rd_pad[PINS-1:0] = fall_q;
            BANK_RISE:   rd_pad[PINS-1:0] = rise_q;
            BANK_POL:    rd_pad[PINS-1:0] = pol_q;
            BANK_STATUS: rd_pad[PINS-1:0] = stat_q;
            default:     rd_pad = '0;
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned && sel.timer_hit) begin
            bus_rdata = timer_q[sel.timer_idx];
        end else if (aligned && sel.bank_hit) begin
            bus_rdata = rd_pad[int'(sel.word)*WORD_W +: WORD_W];
        end
    end

    for (genvar p = 0; p < PINS; p++) begin : g_cfg
        assign cfg_o[p].enable = en_q[p];
        assign cfg_o[p].rise   = rise_q[p];
        assign cfg_o[p].fall   = fall_q[p];
        assign cfg_o[p].pol    = pol_q[p];
    end

    assign en_o      = en_q;
    assign status_o  = stat_q;
    assign stat_wr_o = wr_stat;
endmodule

// File: rtl/wake_monitor.sv
`timescale 1ns/1ps
module wake_monitor
    import wkm_pkg::*;
#(
    parameter int PINS        = 40,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pins_i,
    input  logic              doorbell,
    output logic              wake_req,
    output logic              asleep
);
    logic     [PINS-1:0] pin_cur, pin_prev, evt_w, en_w, status_w;
    pin_cfg_t [PINS-1:0] cfg_w;
    logic                stat_wr_w;
    logic                wake_q, asleep_q;

    wkm_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(pins_i),
        .sync_o(pin_cur), .prev_o(pin_prev)
    );

    wkm_detect #(.PINS(PINS)) u_detect (
        .cur_i(pin_cur), .prev_i(pin_prev), .cfg_i(cfg_w), .evt_o(evt_w)
    );

    wkm_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_w),
        .cfg_o(cfg_w), .en_o(en_w), .status_o(status_w), .stat_wr_o(stat_wr_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q   <= 1'b0;
            asleep_q <= 1'b0;
        end else begin
            wake_q <= |(status_w & en_w);
            if (wake_q)        asleep_q <= 1'b0;
            else if (doorbell) asleep_q <= 1'b1;
        end
    end

    assign wake_req = wake_q;
    assign asleep   = asleep_q;
endmodule

// File: rtl/wake_monitor_chk.sv
`timescale 1ns/1ps
module wake_monitor_chk #(
    parameter int PINS   = 40,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              doorbell,
    input logic              wake_req,
    input logic              asleep,
    input logic [PINS-1:0]   status_vec,
    input logic [PINS-1:0]   en_vec,
    input logic              stat_wr
);
    localparam int END_WORD = 5 * ((PINS + 31) / 32) + 2;

    // R1
    p_reset_quiet_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!wake_req && !asleep && status_vec == '0));

    // R3
    p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr[ADDR_W-1:2]) >= END_WORD) |-> (bus_rdata == '0));

    // R7
    p_disabled_no_set_r7: assert property (@(posedge clk) disable iff (rst)
        (status_vec & ~$past(status_vec) & ~$past(en_vec)) == '0);

    // R8
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> (($past(status_vec) & ~status_vec) == '0));

    // R9
    p_wake_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(status_vec & en_vec) == '0) |-> !wake_req);

    // R10
    p_doorbell_sets_r10: assert property (@(posedge clk) disable iff (rst)
        (doorbell && !wake_req) |=> asleep);

    p_wake_clears_r10: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !asleep);
endmodule

bind wake_monitor wake_monitor_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .doorbell(doorbell), .wake_req(wake_req), .asleep(asleep),
    .status_vec(status_w), .en_vec(en_w), .stat_wr(stat_wr_w)
);

// File: tb/wake_monitor_tb.sv
`timescale 1ns/1ps
module wake_monitor_tb;
    localparam int PINS   = 40;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_wr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [PINS-1:0]   pins_i;
    logic              doorbell;
    logic              wake_req;
    logic              asleep;

    int total = 0;
    int bad   = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    wake_monitor #(.PINS(PINS), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_i(pins_i),
        .doorbell(doorbell), .wake_req(wake_req), .asleep(asleep)
    );

    // {address, write data, expected read-back}
    localparam logic [95:0] VEC [0:6] = '{
        {32'h2C, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h00, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {32'h04, 32'h1234_5678, 32'h1234_5678},
        {32'h18, 32'h0000_FFFF, 32'h0000_FFFF},
        {32'h14, 32'h0000_0001, 32'h0000_0001},
        {32'h24, 32'hFFFF_0080, 32'h0000_0080},
        {32'h30, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        pins_i = '0; doorbell = 1'b0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        rd_now(8'h08, rv); chk("R1 enable word", rv, 32'h0);
        rd_now(8'h28, rv); chk("R1 status word", rv, 32'h0);
        chk("R1 wake_req", 32'(wake_req), 32'h0);
        chk("R1 asleep", 32'(asleep), 32'h0);

        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd_now(VEC[i][71:64], rv);
            chk($sformatf("R2/R3/R8 table row %0d", i), rv, VEC[i][31:0]);
        end
        rd_now(8'h1D, rv); chk("R3 misaligned read", rv, 32'h0);

        @(negedge clk); rst = 1'b1;
        wait_n(2); rst = 1'b0;
        wait_n(1);
        rd_now(8'h00, rv); chk("R1 timer after reset", rv, 32'h0);
        rd_now(8'h18, rv); chk("R1 rise after reset", rv, 32'h0);
        rd_now(8'h24, rv); chk("R1 pol after reset", rv, 32'h0);

        // R4 rising edge on pin 3 with exact latency
        wr(8'h18, 32'h8);
        wr(8'h08, 32'h8);
        @(negedge clk); pins_i[3] = 1'b1;
        wait_n(3);
        rd_now(8'h28, rv); chk("R4 status after edge", rv, 32'h8);
        chk("R9 wake not yet", 32'(wake_req), 32'h0);
        wait_n(1);
        chk("R9 wake one cycle later", 32'(wake_req), 32'h1);
        pins_i[3] = 1'b0;
        wait_n(5);
        wr(8'h28, 32'h0);
        wait_n(4);
        rd_now(8'h28, rv); chk("R8 clear by zero", rv, 32'h0);
        chk("R9 wake drops", 32'(wake_req), 32'h0);

        // R5 falling only on pin 35
        wr(8'h14, 32'h8);
        wr(8'h0C, 32'h8);
        pins_i[35] = 1'b1;
        wait_n(5);
        rd_now(8'h2C, rv); chk("R5 rising ignored", rv, 32'h0);
        pins_i[35] = 1'b0;
        wait_n(5);
        rd_now(8'h2C, rv); chk("R5 falling sets", rv, 32'h8);
        wr(8'h2C, 32'h0);
        wait_n(3);
        rd_now(8'h2C, rv); chk("R8 clear word1", rv, 32'h0);

        // R5 both edges on pin 3
        wr(8'h10, 32'h8);
        pins_i[3] = 1'b1;
        wait_n(5);
        rd_now(8'h28, rv); chk("R5 both rise", rv, 32'h8);
        wr(8'h28, 32'h0);
        wait_n(3);
        rd_now(8'h28, rv); chk("R8 clear both", rv, 32'h0);
        pins_i[3] = 1'b0;
        wait_n(5);
        rd_now(8'h28, rv); chk("R5 both fall", rv, 32'h8);
        wr(8'h28, 32'h0);
        wait_n(3);

        // R7 disabled pin 4
        wr(8'h18, 32'h18);
        pins_i[4] = 1'b1;
        wait_n(5);
        pins_i[4] = 1'b0;
        wait_n(5);
        rd_now(8'h28, rv); chk("R7 disabled ignored", rv, 32'h0);
        chk("R7 no wake", 32'(wake_req), 32'h0);

        // R6 level sensing on pin 5
        wr(8'h20, 32'h20);
        wr(8'h08, 32'h28);
        wait_n(5);
        rd_now(8'h28, rv); chk("R6 level high inactive", rv, 32'h0);
        pins_i[5] = 1'b1;
        wait_n(5);
        rd_now(8'h28, rv); chk("R6 level high active", rv, 32'h20);
        chk("R9 wake on level", 32'(wake_req), 32'h1);
        wr(8'h28, 32'h0);
        wait_n(1);
        rd_now(8'h28, rv); chk("R8 set wins over clear", rv, 32'h20);
        pins_i[5] = 1'b0;
        wait_n(5);
        wr(8'h28, 32'h0);
        wait_n(3);
        rd_now(8'h28, rv); chk("R8 clear after level ends", rv, 32'h0);
        wr(8'h20, 32'h0);
        wait_n(5);
        rd_now(8'h28, rv); chk("R6 level low active", rv, 32'h20);
        wr(8'h08, 32'h8);
        wait_n(3);
        chk("R9 disable drops wake", 32'(wake_req), 32'h0);
        rd_now(8'h28, rv); chk("R9 status kept", rv, 32'h20);
        wr(8'h28, 32'h0);
        wait_n(3);

        // R10 doorbell and wake
        @(negedge clk); doorbell = 1'b1;
        @(negedge clk); doorbell = 1'b0;
        chk("R10 asleep set", 32'(asleep), 32'h1);
        wait_n(3);
        chk("R10 asleep holds", 32'(asleep), 32'h1);
        pins_i[3] = 1'b1;
        wait_n(6);
        chk("R10 wake raised", 32'(wake_req), 32'h1);
        chk("R10 asleep cleared", 32'(asleep), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule